// File: doc/BRIEF.md
# Front-End Command Keep-Alive Scheduler

This block drives the single command stream that a readout controller sends to a group of front-end chips. Three sources share the stream. Upstream trigger logic offers commands through a request/grant handshake. A dedicated recover strobe becomes a chip-reset broadcast. An internal idle timer supplies keep-alive commands. Without the keep-alives, chips that hear nothing for too long can fall into an undefined state in which they draw a large current.

The stream carries at most one command per clock. Each command appears as a code on `cmd_out` together with a one-cycle `cmd_valid` strobe. Any command that goes out restarts the idle interval, so keep-alives appear only when the stream has been quiet. The default interval is 2045 clocks, which is about 270 µs at a 132 ns clock. A sticky flag reports that at least one keep-alive has gone out since software last cleared it. The block sends only the reset broadcast and never a configuration sequence.

Top module: `keepalive_cmd_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `cmd_valid` and `ka_seen` are 0.
- R2: If no command is issued, a keep-alive (code 4'h1) appears exactly IDLE_TICKS cycles after the previous strobe, or after reset release. Strobes are never more than IDLE_TICKS cycles apart.
- R3: A trigger command restarts the idle interval. The next keep-alive comes IDLE_TICKS cycles after that trigger's strobe.
- R4: A one-cycle pulse on `recover` produces a chip-reset broadcast (code 4'hE) with `cmd_valid` two cycles later.
- R5: While a recover request is pending (the cycle after the pulse), `req_grant` stays low even if `req_valid` is high. The request is granted in the following cycle.
- R6: If `req_valid` is high and no recover is pending, `req_grant` is high in the same cycle and `req_cmd` appears on `cmd_out` in the next cycle. Upstream codes must differ from 4'h1 and 4'hE.
- R7: If a keep-alive falls due in the same cycle that a trigger is granted, only the trigger goes out. The keep-alive is dropped and the interval restarts from the trigger.
- R8: `cmd_valid` lasts one cycle per command, and `cmd_out` is 0 whenever `cmd_valid` is low.
- R9: `ka_seen` goes high with the first keep-alive strobe and stays high until `ka_clear`. If a clear coincides with a keep-alive being issued, the flag stays set.
- R10: A synchronous reset discards a pending recover request, so no chip reset follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream command offered |
| req_cmd | input | CMD_W | Offered command code |
| req_grant | output | 1 | Offered command accepted this cycle |
| recover | input | 1 | Recovery pulse requesting a chip-reset broadcast |
| ka_clear | input | 1 | Clears the keep-alive sticky flag |
| cmd_out | output | CMD_W | Command code to the chips |
| cmd_valid | output | 1 | One-cycle command strobe |
| ka_seen | output | 1 | Sticky: a keep-alive has been issued |

## Verification
The hardest case to reach is a keep-alive falling due in exactly the cycle that a trigger is granted. The stimulus counts cycles from the last observed strobe with a short interval parameter and raises `req_valid` in the final cycle of that interval. The bench then checks that the trigger wins and that the next keep-alive is timed from the trigger. A clear that lands on the keep-alive issue cycle is produced the same way. A recover pulse followed at once by reset is used to show that the pending request is discarded.

// File: rtl/ka_pkg.sv
package ka_pkg;
  localparam int KA_CMD_W = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RST  = 2'd1,
    SEL_TRIG = 2'd2,
    SEL_KA   = 2'd3
  } ka_sel_e;
endpackage

// File: rtl/ka_idle_timer.sv
module ka_idle_timer #(
  parameter int IDLE_TICKS = 2045
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic due
);
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (restart)   cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign due = (cnt == LAST);
endmodule

// File: rtl/ka_recover_latch.sv
module ka_recover_latch (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  input  logic taken,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)        pend <= 1'b0;
    else if (pulse) pend <= 1'b1;
    else if (taken) pend <= 1'b0;
  end
endmodule

// File: rtl/ka_arbiter.sv
module ka_arbiter
  import ka_pkg::*;
(
  input  logic    rst_pend,
  input  logic    req_valid,
  input  logic    due,
  output ka_sel_e sel,
  output logic    grant
);
  always_comb begin
    grant = 1'b0;
    if (rst_pend)       sel = SEL_RST;
    else if (req_valid) begin
      sel   = SEL_TRIG;
      grant = 1'b1;
    end
    else if (due)       sel = SEL_KA;
    else                sel = SEL_NONE;
  end
endmodule

// File: rtl/keepalive_cmd_sched.sv
module keepalive_cmd_sched
  import ka_pkg::*;
#(
  parameter int IDLE_TICKS = 2045,
  parameter int CMD_W = KA_CMD_W,
  parameter logic [CMD_W-1:0] KEEPALIVE_CODE = CMD_W'(1),
  parameter logic [CMD_W-1:0] CHIPRST_CODE = CMD_W'(14)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CMD_W-1:0] req_cmd,
  output logic             req_grant,
  input  logic             recover,
  input  logic             ka_clear,
  output logic [CMD_W-1:0] cmd_out,
  output logic             cmd_valid,
  output logic             ka_seen
);
  ka_sel_e          sel;
  logic             due;
  logic             rst_pend;
  logic             issue;
  logic [CMD_W-1:0] next_cmd;

  assign issue = (sel != SEL_NONE);

  ka_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_timer (
    .clk(clk), .rst(rst), .restart(issue), .due(due)
  );

  ka_recover_latch u_recover (
    .clk(clk), .rst(rst), .pulse(recover),
    .taken(sel == SEL_RST), .pend(rst_pend)
  );

  ka_arbiter u_arb (
    .rst_pend(rst_pend), .req_valid(req_valid), .due(due),
    .sel(sel), .grant(req_grant)
  );

  always_comb begin
    unique case (sel)
      SEL_RST:  next_cmd = CHIPRST_CODE;
      SEL_TRIG: next_cmd = req_cmd;
      SEL_KA:   next_cmd = KEEPALIVE_CODE;
      default:  next_cmd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_out   <= '0;
      cmd_valid <= 1'b0;
      ka_seen   <= 1'b0;
    end else begin
      cmd_out   <= next_cmd;
      cmd_valid <= issue;
      if (sel == SEL_KA)  ka_seen <= 1'b1;
      else if (ka_clear)  ka_seen <= 1'b0;
    end
  end
endmodule

// File: rtl/ka_sched_checker.sv
module ka_sched_checker #(
  parameter int IDLE_TICKS = 2045,
  parameter int CMD_W = 4,
  parameter logic [CMD_W-1:0] KEEPALIVE_CODE = CMD_W'(1),
  parameter logic [CMD_W-1:0] CHIPRST_CODE = CMD_W'(14)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [CMD_W-1:0] req_cmd,
  input logic             req_grant,
  input logic             recover,
  input logic             ka_clear,
  input logic [CMD_W-1:0] cmd_out,
  input logic             cmd_valid,
  input logic             ka_seen
);
  localparam int SW = $clog2(IDLE_TICKS + 2);
  localparam logic [SW-1:0] LIM = SW'(IDLE_TICKS);

  logic [SW-1:0] since;
  always_ff @(posedge clk) begin
    if (rst)                since <= '0;
    else if (cmd_valid)     since <= SW'(1);
    else if (since <= LIM)  since <= since + 1'b1;
  end

  assert_ka_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_out == KEEPALIVE_CODE) |-> since == LIM);
  assert_idle_bound_R2: assert property (@(posedge clk) disable iff (rst)
    since <= LIM);
  assert_recover_delay_R4: assert property (@(posedge clk) disable iff (rst)
    recover |=> ##1 (cmd_valid && cmd_out == CHIPRST_CODE));
  assert_grant_blocked_R5: assert property (@(posedge clk) disable iff (rst)
    recover |=> !req_grant);
  assert_grant_forward_R6: assert property (@(posedge clk) disable iff (rst)
    req_grant |=> (cmd_valid && cmd_out == $past(req_cmd)));
  assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
    req_grant |-> req_valid);
  assert_clean_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> cmd_out == '0);
  assert_sticky_set_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_out == KEEPALIVE_CODE) |-> ka_seen);
  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ka_seen) |-> $past(ka_clear));
endmodule

bind keepalive_cmd_sched ka_sched_checker #(
  .IDLE_TICKS(IDLE_TICKS), .CMD_W(CMD_W),
  .KEEPALIVE_CODE(KEEPALIVE_CODE), .CHIPRST_CODE(CHIPRST_CODE)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_grant(req_grant), .recover(recover), .ka_clear(ka_clear),
  .cmd_out(cmd_out), .cmd_valid(cmd_valid), .ka_seen(ka_seen)
);

// File: tb/tb_keepalive_cmd_sched.sv
`timescale 1ns/1ps
module tb_keepalive_cmd_sched;
  localparam int IDLE = 20;
  localparam logic [3:0] KA = 4'h1;
  localparam logic [3:0] CR = 4'hE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [3:0] req_cmd = '0;
  logic req_grant;
  logic recover = 1'b0;
  logic ka_clear = 1'b0;
  logic [3:0] cmd_out;
  logic cmd_valid;
  logic ka_seen;

  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  keepalive_cmd_sched #(.IDLE_TICKS(IDLE)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_grant(req_grant), .recover(recover), .ka_clear(ka_clear),
    .cmd_out(cmd_out), .cmd_valid(cmd_valid), .ka_seen(ka_seen)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0; recover = 1'b0; ka_clear = 1'b0;
    step(3);
    check(cmd_valid == 1'b0, "R1 valid in reset", cmd_valid, 0);
    rst = 1'b0;
  endtask

  // Expects no strobe for IDLE-1 negedges, then a keep-alive.
  task automatic expect_ka(input string tag);
    bit early = 1'b0;
    for (int i = 1; i < IDLE; i++) begin
      step(1);
      if (cmd_valid) early = 1'b1;
    end
    check(!early, {tag, " no early strobe"}, early, 0);
    step(1);
    check(cmd_valid && cmd_out == KA, {tag, " keep-alive"}, {cmd_valid, cmd_out}, {1'b1, KA});
  endtask

  task automatic t_reset();
    do_reset();
    check(cmd_valid == 0 && ka_seen == 0, "R1 after release", {cmd_valid, ka_seen}, 0);
  endtask

  task automatic t_period();
    do_reset();
    expect_ka("R2 first");
    step(1);
    check(!cmd_valid && cmd_out == 0, "R8 strobe one cycle", {cmd_valid, cmd_out}, 0);
    step(IDLE - 2);
    expect_ka_after_one("R2 second");
  endtask

  task automatic expect_ka_after_one(input string tag);
    step(1);
    check(cmd_valid && cmd_out == KA, tag, {cmd_valid, cmd_out}, {1'b1, KA});
  endtask

  task automatic t_trigger();
    do_reset();
    step(5);
    req_valid = 1'b1; req_cmd = 4'h6;
    #1 check(req_grant == 1'b1, "R6 grant", req_grant, 1);
    step(1);
    req_valid = 1'b0;
    check(cmd_valid && cmd_out == 4'h6, "R6 forwarded", {cmd_valid, cmd_out}, {1'b1, 4'h6});
    expect_ka("R3 restart");
  endtask

  task automatic t_collision();
    do_reset();
    expect_ka("R7 setup");
    step(IDLE - 1);
    req_valid = 1'b1; req_cmd = 4'h9;
    step(1);
    req_valid = 1'b0;
    check(cmd_valid && cmd_out == 4'h9, "R7 trigger wins", {cmd_valid, cmd_out}, {1'b1, 4'h9});
    expect_ka("R7 interval from trigger");
  endtask

  task automatic t_recover();
    do_reset();
    step(3);
    recover = 1'b1;
    step(1);
    recover = 1'b0; req_valid = 1'b1; req_cmd = 4'h5;
    check(!cmd_valid, "R4 no strobe yet", cmd_valid, 0);
    #1 check(req_grant == 1'b0, "R5 grant blocked", req_grant, 0);
    step(1);
    check(cmd_valid && cmd_out == CR, "R4 chip reset", {cmd_valid, cmd_out}, {1'b1, CR});
    #1 check(req_grant == 1'b1, "R5 grant after reset", req_grant, 1);
    step(1);
    req_valid = 1'b0;
    check(cmd_valid && cmd_out == 4'h5, "R5 deferred trigger", {cmd_valid, cmd_out}, {1'b1, 4'h5});
  endtask

  task automatic t_sticky();
    do_reset();
    expect_ka("R9 setup");
    check(ka_seen == 1'b1, "R9 set", ka_seen, 1);
    ka_clear = 1'b1;
    step(1);
    ka_clear = 1'b0;
    check(ka_seen == 1'b0, "R9 cleared", ka_seen, 0);
    step(IDLE - 2);
    ka_clear = 1'b1;
    step(1);
    ka_clear = 1'b0;
    check(cmd_valid && cmd_out == KA && ka_seen, "R9 set wins over clear",
          {cmd_valid, cmd_out, ka_seen}, {1'b1, KA, 1'b1});
  endtask

  task automatic t_reset_drops_recover();
    bit seen = 1'b0;
    do_reset();
    step(2);
    recover = 1'b1;
    step(1);
    recover = 1'b0; rst = 1'b1;
    step(2);
    rst = 1'b0;
    for (int i = 0; i < IDLE - 1; i++) begin
      step(1);
      if (cmd_valid) seen = 1'b1;
    end
    check(!seen, "R10 pending recover discarded", seen, 0);
  endtask

  initial begin
    t_reset();
    t_period();
    t_trigger();
    t_collision();
    t_recover();
    t_sticky();
    t_reset_drops_recover();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule